// File: doc/BRIEF.md
# Two-Wire Slave Address Front End with High-Speed Mode Tracking

This block is the receiving front end of a two-wire serial slave. A fast system clock oversamples the SCL and SDA lines. The block finds start, repeated start and stop conditions and shifts in the first byte after each start. It then decides whether that byte names this slave. A matching address is acknowledged through an open-drain pull-down enable. When an address is accepted, a one-cycle pulse tells the downstream data logic, and the pulse carries the requested transfer direction.

The same byte check also looks for the high-speed master code, a byte of the form 0000_1xxx. Every slave must recognise this code, whatever its own address is. The block answers it with a not-acknowledge and then raises a sticky high-speed flag. It then waits for a repeated start and an address, which it handles in the usual way. Only a stop condition clears the flag. The data bytes that follow an accepted address, clock stretching and the timing differences between speed modes are handled elsewhere.

Top module: `twi_addr_front`

## Requirements
- R1: After reset, hs_mode is 0 (fast/standard), sda_pull is 0 (SDA released) and addr_hit is 0.
- R2: When a start is followed by a byte whose upper seven bits (sent first, MSB first) equal the slave address, the block pulls SDA low (sda_pull = 1) throughout the high phase of the ninth SCL clock. It releases SDA after the falling edge of that clock.
- R3: After the acknowledge is released, addr_hit pulses high for exactly one system clock, and rw_flag equals the last bit of the address byte (0 = write, 1 = read).
- R4: On an address mismatch, the block gives no acknowledge and no addr_hit pulse. It ignores later bytes until the next start, even if one of those bytes would match.
- R5: A byte clocked on the bus without a preceding start is ignored: there is no acknowledge and no addr_hit.
- R6: A byte matching 0000_1xxx after a start is taken as the high-speed master code, whatever the slave address is. SDA stays released during its ninth clock, and hs_mode becomes 1 after that clock.
- R7: While hs_mode is 1, a repeated start followed by a matching address is acknowledged and reported as in R2 and R3, and hs_mode stays 1.
- R8: Any stop condition returns hs_mode to 0.
- R9: The parameter ALT_ADDR selects the slave address: 0 gives 7'b0110100, and 1 gives 7'b0110101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line as received (asynchronous) |
| sda_in | input | 1 | SDA line as received (asynchronous) |
| sda_pull | output | 1 | Open-drain enable: 1 drives SDA low |
| addr_hit | output | 1 | One-cycle pulse when an address has been acknowledged |
| rw_flag | output | 1 | Direction bit of the last accepted address (1 = read) |
| hs_mode | output | 1 | 1 while in high-speed mode, 0 in fast/standard mode |

## Verification
The bench builds two copies of the block on one shared bus, one with ALT_ADDR = 0 and one with ALT_ADDR = 1. This lets it show, from a single stream of bus traffic, that each copy answers only its own address while both treat the master code alike. The pairing also shows that an address which one copy acknowledges is a mismatch for the other. The default copy additionally goes through the high-speed entry, a repeated start address and the fall back on stop.

// File: rtl/twi_front_pkg.sv
// Package: shared types for the two-wire address front end.
// Assumes: nothing beyond IEEE 1800-2017.
package twi_front_pkg;

    // Address-phase sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a start condition
        ST_SHIFT,     // shifting in the first byte
        ST_ACK_WAIT,  // matched; waiting for the end of the eighth clock
        ST_ACK_DRIVE, // pulling SDA low through the ninth clock
        ST_NACK,      // master code seen; letting the ninth clock pass
        ST_HOLD       // addressed; data phase belongs to other logic
    } front_state_t;

    localparam int BYTE_BITS = 8;

    // Fixed slave addresses that can be selected.
    localparam logic [6:0] ADDR_BASE = 7'b0110100;
    localparam logic [6:0] ADDR_ALT  = 7'b0110101;

endpackage

// File: rtl/twi_sync.sv
// Module: multi-bit flop-chain synchronizer for asynchronous bus lines.
// Assumes: each bit is an independent slow level; the reset value is the
// idle-high level of an open-drain bus.
module twi_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0] chain [WIDTH];

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            // Shift each line through its own chain of flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '1;
                else        chain[g] <= {chain[g][STAGES-2:0], async_in[g]};
            end
            assign sync_out[g] = chain[g][STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/twi_cond_detect.sv
// Module: finds SCL edges and the start and stop conditions in the
// synchronized line levels.
// Assumes: inputs are already synchronized to clk.
module twi_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q, sda_q;

    // Hold the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_addr_seq.sv
// Module: address-phase sequencer. It shifts in the first byte after a
// start, acknowledges a matching address, answers the high-speed master
// code with a not-acknowledge and keeps the speed mode flag.
// Assumes: event inputs are single-cycle pulses from twi_cond_detect.
module twi_addr_seq
    import twi_front_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = ADDR_BASE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    output logic sda_pull,
    output logic addr_hit,
    output logic rw_flag,
    output logic hs_mode
);

    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    front_state_t           state;
    logic [BYTE_BITS-1:0]   shreg;
    logic [BYTE_BITS-1:0]   next_byte;
    logic [CNT_W-1:0]       bit_cnt;
    logic                   ninth_seen;
    logic                   is_match;
    logic                   is_master_code;

    // Byte as it will be once the current bit has been shifted in.
    assign next_byte      = {shreg[BYTE_BITS-2:0], sda_s};
    assign is_match       = (next_byte[7:1] == OWN_ADDR);
    assign is_master_code = (next_byte[7:3] == 5'b00001);

    // Sequence the address phase and the speed mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_cnt    <= '0;
            ninth_seen <= 1'b0;
            sda_pull   <= 1'b0;
            addr_hit   <= 1'b0;
            rw_flag    <= 1'b0;
            hs_mode    <= 1'b0;
        end else begin
            addr_hit <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                hs_mode  <= 1'b0;
            end else if (start_det) begin
                state    <= ST_SHIFT;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_SHIFT: begin
                        if (scl_rise) begin
                            shreg      <= next_byte;
                            bit_cnt    <= bit_cnt + 1'b1;
                            ninth_seen <= 1'b0;
                            if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
                                if (is_match)            state <= ST_ACK_WAIT;
                                else if (is_master_code) state <= ST_NACK;
                                else                     state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK_DRIVE;
                        end
                    end
                    ST_ACK_DRIVE: begin
                        if (scl_rise) ninth_seen <= 1'b1;
                        if (scl_fall && ninth_seen) begin
                            sda_pull <= 1'b0;
                            addr_hit <= 1'b1;
                            rw_flag  <= shreg[0];
                            state    <= ST_HOLD;
                        end
                    end
                    ST_NACK: begin
                        if (scl_rise) ninth_seen <= 1'b1;
                        if (scl_fall && ninth_seen) begin
                            hs_mode <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Marks that at least one cycle has passed since reset, for $past use.
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: the pull-down only ever changes while SCL is low.
    assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (sda_pull != $past(sda_pull)) |-> !$past(scl_s));

    // R2: an address is reported only after an acknowledge was driven.
    assert_hit_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && addr_hit |-> $past(sda_pull));

    // R3: the addressed pulse lasts one cycle.
    assert_hit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |=> !addr_hit);

    // R6: entering high-speed mode never coincides with an acknowledge.
    assert_hs_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(hs_mode) |-> !sda_pull && !$past(sda_pull));

    // R8: a stop always leaves fast/standard mode selected.
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

endmodule

// File: rtl/twi_addr_front.sv
// Module: top of the two-wire slave address front end. It synchronizes
// the bus lines, detects bus conditions and runs the address sequencer.
// Assumes: clk is several times faster than SCL, and sda_pull drives an
// external open-drain pad.
module twi_addr_front
    import twi_front_pkg::*;
#(
    parameter bit ALT_ADDR    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull,
    output logic addr_hit,
    output logic rw_flag,
    output logic hs_mode
);

    localparam logic [6:0] SLAVE_ADDR = ALT_ADDR ? ADDR_ALT : ADDR_BASE;

    logic [1:0] lines_s;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    twi_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_addr_seq #(.OWN_ADDR(SLAVE_ADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull),
        .addr_hit  (addr_hit),
        .rw_flag   (rw_flag),
        .hs_mode   (hs_mode)
    );

endmodule

// File: tb/tb_twi_addr_front.sv
// Bench: a bus master drives both copies of the block on a shared bus. A
// scoreboard queue holds the expected addressed reports of the default copy.
module tb_twi_addr_front;

    localparam int HALF = 20;  // system clocks per SCL phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic pull_a, hit_a, rw_a, hs_a;
    logic pull_b, hit_b, rw_b, hs_b;

    int tests = 0;
    int fails = 0;
    bit exp_q [$];
    int alt_hits = 0;

    always #2 clk = ~clk;  // 250 MHz

    assign sda_line = sda_m & ~pull_a & ~pull_b;

    twi_addr_front #(.ALT_ADDR(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(pull_a), .addr_hit(hit_a), .rw_flag(rw_a), .hs_mode(hs_a)
    );

    twi_addr_front #(.ALT_ADDR(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(pull_b), .addr_hit(hit_b), .rw_flag(rw_b), .hs_mode(hs_b)
    );

    task automatic chk(input bit ok, input string req,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare expected reports of the default copy.
    always @(negedge clk) begin
        if (rst_n && hit_a) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected addr_hit", 1, 0);
            end else begin
                automatic bit e = exp_q.pop_front();
                chk(rw_a == e, "R3 rw_flag", rw_a, e);
            end
        end
        if (rst_n && hit_b) alt_hits++;
    end

    task automatic bus_start();
        sda_m = 1'b1; wait_n(HALF);
        scl_m = 1'b1; wait_n(HALF);
        sda_m = 1'b0; wait_n(HALF);
        scl_m = 1'b0; wait_n(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_n(HALF);
        scl_m = 1'b1; wait_n(HALF);
        sda_m = 1'b1; wait_n(HALF);
    endtask

    // Sends a byte, then samples both pull enables mid ninth-clock high.
    task automatic send_byte(input logic [7:0] b,
                             output bit ack_a, output bit ack_b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(HALF);
            scl_m = 1'b1; wait_n(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_n(HALF);
        scl_m = 1'b1; wait_n(HALF / 2);
        ack_a = pull_a;
        ack_b = pull_b;
        wait_n(HALF / 2);
        scl_m = 1'b0; wait_n(HALF);
    endtask

    initial begin
        bit aa, ab;
        wait_n(5);
        // R1: reset state
        chk(hs_a == 1'b0, "R1 hs_mode", hs_a, 0);
        chk(pull_a == 1'b0, "R1 sda_pull", pull_a, 0);
        chk(hit_a == 1'b0, "R1 addr_hit", hit_a, 0);
        rst_n = 1'b1;
        wait_n(10);

        // R5: byte with no start before it
        scl_m = 1'b0; wait_n(HALF);
        send_byte(8'h68, aa, ab);
        chk(aa == 1'b0, "R5 no ack without start", aa, 0);
        bus_stop();

        // R2/R3: write to own address
        exp_q.push_back(1'b0);
        bus_start();
        send_byte(8'h68, aa, ab);
        chk(aa == 1'b1, "R2 ack on match", aa, 1);
        chk(pull_a == 1'b0, "R2 released after ninth", pull_a, 0);
        chk(ab == 1'b0, "R9 alt ignores base address", ab, 0);
        bus_stop();

        // R3: read to own address
        exp_q.push_back(1'b1);
        bus_start();
        send_byte(8'h69, aa, ab);
        chk(aa == 1'b1, "R3 ack on read", aa, 1);
        bus_stop();

        // R4/R9: alternate address, then matching byte without new start
        bus_start();
        send_byte(8'h6A, aa, ab);
        chk(aa == 1'b0, "R4 no ack on mismatch", aa, 0);
        chk(ab == 1'b1, "R9 alt acks its address", ab, 1);
        send_byte(8'h68, aa, ab);
        chk(aa == 1'b0, "R4 ignored until next start", aa, 0);
        bus_stop();

        // R6/R7/R8: master code, repeated start, stop
        bus_start();
        send_byte(8'h0D, aa, ab);
        chk(aa == 1'b0 && ab == 1'b0, "R6 nack master code", {aa, ab}, 0);
        chk(hs_a == 1'b1, "R6 hs_mode set", hs_a, 1);
        chk(hs_b == 1'b1, "R6 hs_mode set on alt", hs_b, 1);
        exp_q.push_back(1'b1);
        bus_start();
        send_byte(8'h69, aa, ab);
        chk(aa == 1'b1, "R7 ack in high-speed mode", aa, 1);
        chk(hs_a == 1'b1, "R7 hs_mode kept", hs_a, 1);
        bus_stop();
        wait_n(10);
        chk(hs_a == 1'b0, "R8 stop clears hs_mode", hs_a, 0);

        // R6/R8: other master code value, then immediate stop
        bus_start();
        send_byte(8'h08, aa, ab);
        chk(hs_a == 1'b1, "R6 hs_mode on 0x08", hs_a, 1);
        bus_stop();
        wait_n(10);
        chk(hs_a == 1'b0, "R8 hs_mode cleared again", hs_a, 0);

        wait_n(20);
        chk(exp_q.size() == 0, "R3 missing addr_hit", exp_q.size(), 0);
        chk(alt_hits == 1, "R9 alt addr_hit count", alt_hits, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule